// File: doc/BRIEF.md
# Posttrigger Acquisition Gating Controller

This block decides which external conversion requests reach the A/D converter during a posttrigger acquisition. Software arms it with a one-cycle request. From that point each falling edge on an active-low convert input produces a one-clock conversion-start strobe. A rising edge on a trigger input opens the counting phase. Only conversions after that edge reduce the sample budget, which is loaded at arming.

There are two ways to end a run. In counted mode the controller closes the gate as soon as the budget is spent. In freerun mode it never counts, and software keeps track of the samples. It closes the gate by writing a halt code (0x34 by default) to the counter mode register port. A software-visible gate bit shows whether convert edges are currently accepted.

The controller is a three-state machine. IDLE means the gate is closed. ARMED means conversions are strobed but not counted, and the block waits for the trigger. RUN means conversions are strobed, and in counted mode they are counted. The named transitions are:

- arm: any state to ARMED.
- trigger: ARMED to RUN.
- count-done: RUN to IDLE, in counted mode, on the last counted conversion.
- halt: any state to IDLE, on a write of the halt code.

Top module: `acq_gate_ctrl`

## Requirements
- R1: After reset the gate bit is 0 and no strobe is issued. Convert edges seen while idle produce no strobe.
- R2: A cycle with `arm_i`=1 (and no halt write) sets the gate bit to 1 in the next cycle and reloads the sample budget from `count_i`. Re-arming after a finished run opens the gate again.
- R3: Both asynchronous inputs pass through a two-flop synchronizer. A falling edge on `conv_n_i` while the gate is open raises `conv_start_o` for exactly one clock, three clock edges after the input changes.
- R4: Conversions before the trigger edge are strobed but do not reduce the sample budget.
- R5: The first rising edge on `trig_i` after arming starts counting. Later trigger edges have no effect until software arms again.
- R6: In counted mode (`freerun_i`=0), with budget N, the Nth counted conversion is strobed and the gate bit falls in that same cycle. A budget of 0 behaves as 1.
- R7: While the gate bit is 0, convert edges produce no strobe.
- R8: In freerun mode (`freerun_i`=1) counted conversions never close the gate.
- R9: A write with `mode_wr_i`=1 and `mode_data_i`=0x34 (`HALT_CODE`) closes the gate in the next cycle and drops any strobe in that cycle. Writes of any other value have no effect.
- R10: A halt write in the same cycle as `arm_i` wins, so the gate stays closed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| arm_i | input | 1 | One-cycle software arm request |
| freerun_i | input | 1 | 1 = freerun mode, 0 = counted mode |
| count_i | input | 16 | Sample budget, captured at arming |
| mode_wr_i | input | 1 | Counter mode register write strobe |
| mode_data_i | input | 8 | Counter mode register write data |
| conv_n_i | input | 1 | Asynchronous active-low convert request |
| trig_i | input | 1 | Asynchronous trigger input |
| conv_start_o | output | 1 | One-clock conversion-start strobe |
| gate_o | output | 1 | Gate status bit (1 = convert edges accepted) |

## Verification
The hardest case to reach from the ports is a trigger edge that arrives while a run is already counting. Any reload on that edge would be masked, because the run would still end on its own count. The stimulus therefore arms with a budget of two, counts one conversion, pulses the trigger again, and then expects the gate to fall on the very next conversion. Pre-trigger conversions are interleaved the same way: several strobes are issued before the trigger, and the expected closing point must still be exactly the programmed count after the trigger.

// File: rtl/acq_gate_pkg.sv
package acq_gate_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_RUN   = 2'd2
    } gate_state_e;
endpackage

// File: rtl/edge_sync.sv
module edge_sync #(
    parameter int  SYNC_STAGES = 2,
    parameter bit  RISING      = 1'b1,
    parameter bit  REST_LEVEL  = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic edge_o
);
    logic [SYNC_STAGES-1:0] chain_q;
    logic                   prev_q;
    logic                   synced;

    assign synced = chain_q[SYNC_STAGES-1];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= {SYNC_STAGES{REST_LEVEL}};
            prev_q  <= REST_LEVEL;
        end else begin
            chain_q <= {chain_q[SYNC_STAGES-2:0], async_i};
            prev_q  <= synced;
        end
    end

    generate
        if (RISING) begin : g_rise
            assign edge_o = synced & ~prev_q;
        end else begin : g_fall
            assign edge_o = ~synced & prev_q;
        end
    endgenerate

    AST_EDGE_ONE_WIDE: assert property (@(posedge clk) disable iff (!rst_n)
        edge_o |=> !edge_o); // R3
endmodule

// File: rtl/sample_counter.sv
module sample_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic             dec_i,
    output logic             last_o
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] rem_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q <= '0;
        end else if (load_i) begin
            rem_q <= (load_val_i == '0) ? ONE : load_val_i;
        end else if (dec_i && rem_q != '0) begin
            rem_q <= rem_q - ONE;
        end
    end

    assign last_o = (rem_q == ONE);

    AST_CNT_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        dec_i |-> rem_q != '0); // R6
endmodule

// File: rtl/acq_gate_ctrl.sv
module acq_gate_ctrl
    import acq_gate_pkg::*;
#(
    parameter int          CNT_W       = 16,
    parameter int          MODE_W      = 8,
    parameter int          SYNC_STAGES = 2,
    parameter logic [7:0]  HALT_CODE   = 8'h34
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arm_i,
    input  logic              freerun_i,
    input  logic [CNT_W-1:0]  count_i,
    input  logic              mode_wr_i,
    input  logic [MODE_W-1:0] mode_data_i,
    input  logic              conv_n_i,
    input  logic              trig_i,
    output logic              conv_start_o,
    output logic              gate_o
);
    localparam logic [MODE_W-1:0] HALT_VAL = MODE_W'(HALT_CODE);

    gate_state_e st_q, st_d;
    logic conv_fall, trig_rise;
    logic halt_wr, strobe_d, cnt_load, cnt_dec, cnt_last;

    edge_sync #(.SYNC_STAGES(SYNC_STAGES), .RISING(1'b0), .REST_LEVEL(1'b1)) u_conv_sync (
        .clk(clk), .rst_n(rst_n), .async_i(conv_n_i), .edge_o(conv_fall)
    );

    edge_sync #(.SYNC_STAGES(SYNC_STAGES), .RISING(1'b1), .REST_LEVEL(1'b0)) u_trig_sync (
        .clk(clk), .rst_n(rst_n), .async_i(trig_i), .edge_o(trig_rise)
    );

    sample_counter #(.CNT_W(CNT_W)) u_budget (
        .clk(clk), .rst_n(rst_n), .load_i(cnt_load), .load_val_i(count_i),
        .dec_i(cnt_dec), .last_o(cnt_last)
    );

    assign halt_wr = mode_wr_i && (mode_data_i == HALT_VAL);

    always_comb begin
        st_d     = st_q;
        strobe_d = 1'b0;
        cnt_load = 1'b0;
        cnt_dec  = 1'b0;
        if (halt_wr) begin
            st_d = ST_IDLE;                       // halt
        end else if (arm_i) begin
            st_d     = ST_ARMED;                  // arm
            cnt_load = 1'b1;
        end else begin
            unique case (st_q)
                ST_IDLE: begin
                    st_d = ST_IDLE;
                end
                ST_ARMED: begin
                    strobe_d = conv_fall;
                    if (trig_rise) st_d = ST_RUN; // trigger
                end
                ST_RUN: begin
                    strobe_d = conv_fall;
                    if (conv_fall && !freerun_i) begin
                        cnt_dec = 1'b1;
                        if (cnt_last) st_d = ST_IDLE; // count-done
                    end
                end
                default: st_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) conv_start_o <= 1'b0;
        else        conv_start_o <= strobe_d;
    end

    assign gate_o = (st_q != ST_IDLE);

    AST_NO_IDLE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start_o |-> $past(gate_o)); // R7
    AST_HALT_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_wr_i && mode_data_i == HALT_VAL) |=> (!gate_o && !conv_start_o)); // R9
    AST_ARM_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
        (arm_i && !(mode_wr_i && mode_data_i == HALT_VAL)) |=> gate_o); // R2
    AST_FREERUN_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_o && freerun_i && !mode_wr_i) |=> gate_o); // R8
endmodule

// File: tb/acq_gate_ctrl_test.sv
module acq_gate_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        arm = 1'b0;
    logic        freerun = 1'b0;
    logic [15:0] cnt_cfg = '0;
    logic        mode_wr = 1'b0;
    logic [7:0]  mode_data = '0;
    logic        conv_n = 1'b1;
    logic        trig = 1'b0;
    logic        conv_start;
    logic        gate;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int strobes_seen = 0;
    int strobes_exp = 0;
    bit finished = 1'b0;

    typedef struct {
        int    due;
        bit    strobe;
        bit    gate;
        string tag;
    } exp_item_t;

    exp_item_t sb_q[$];

    always #10 clk = ~clk;

    acq_gate_ctrl uut (
        .clk(clk), .rst_n(rst_n), .arm_i(arm), .freerun_i(freerun),
        .count_i(cnt_cfg), .mode_wr_i(mode_wr), .mode_data_i(mode_data),
        .conv_n_i(conv_n), .trig_i(trig), .conv_start_o(conv_start), .gate_o(gate)
    );

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // monitor: pops scoreboard entries when they fall due
    always @(negedge clk) begin
        if (rst_n && conv_start) strobes_seen++;
        while (sb_q.size() > 0 && sb_q[0].due == cyc) begin
            exp_item_t it;
            it = sb_q.pop_front();
            check(conv_start == it.strobe, {it.tag, " strobe"}, conv_start, it.strobe);
            check(gate == it.gate, {it.tag, " gate"}, gate, it.gate);
        end
    end

    task automatic conv_op(input bit es, input bit eg, input string tag);
        exp_item_t it;
        @(negedge clk);
        conv_n = 1'b0;
        it.due = cyc + 3; it.strobe = es; it.gate = eg; it.tag = tag;
        sb_q.push_back(it);
        if (es) strobes_exp++;
        repeat (4) @(negedge clk);
        conv_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic trig_op();
        @(negedge clk);
        trig = 1'b1;
        repeat (4) @(negedge clk);
        trig = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic arm_op(input logic [15:0] n, input bit fr, input string tag);
        @(negedge clk);
        cnt_cfg = n; freerun = fr; arm = 1'b1;
        @(negedge clk);
        arm = 1'b0;
        check(gate == 1'b1, tag, gate, 1);
    endtask

    task automatic mode_op(input logic [7:0] d, input bit eg, input string tag);
        @(negedge clk);
        mode_wr = 1'b1; mode_data = d;
        @(negedge clk);
        mode_wr = 1'b0;
        check(gate == eg, tag, gate, eg);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(gate == 1'b0, "R1 reset gate", gate, 0);
        check(conv_start == 1'b0, "R1 reset strobe", conv_start, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        conv_op(0, 0, "R1 idle convert");

        // counted run, budget 3, two pre-trigger conversions
        arm_op(16'd3, 1'b0, "R2 arm opens");
        conv_op(1, 1, "R4 pre-trigger a");
        conv_op(1, 1, "R4 pre-trigger b");
        trig_op();
        conv_op(1, 1, "R6 counted 1");
        conv_op(1, 1, "R3 counted 2");
        conv_op(1, 0, "R6 counted last");
        conv_op(0, 0, "R7 after close");
        trig_op();
        conv_op(0, 0, "R5 trigger while idle");

        // second trigger inside a run must not reload
        arm_op(16'd2, 1'b0, "R2 arm budget 2");
        trig_op();
        conv_op(1, 1, "R5 first counted");
        trig_op();
        conv_op(1, 0, "R5 second trigger ignored");

        // zero budget
        arm_op(16'd0, 1'b0, "R2 arm budget 0");
        trig_op();
        conv_op(1, 0, "R6 zero budget");

        // freerun
        arm_op(16'd2, 1'b1, "R2 arm freerun");
        conv_op(1, 1, "R8 freerun pre");
        trig_op();
        for (int i = 0; i < 4; i++) conv_op(1, 1, "R8 freerun counted");
        mode_op(8'h35, 1'b1, "R9 other code ignored");
        conv_op(1, 1, "R9 still open");
        mode_op(8'h34, 1'b0, "R9 halt code");
        conv_op(0, 0, "R9 after halt");

        // halt before trigger in counted mode
        arm_op(16'd5, 1'b0, "R2 arm budget 5");
        mode_op(8'h34, 1'b0, "R9 halt while armed");

        // arm and halt together
        @(negedge clk);
        arm = 1'b1; mode_wr = 1'b1; mode_data = 8'h34;
        @(negedge clk);
        arm = 1'b0; mode_wr = 1'b0;
        check(gate == 1'b0, "R10 halt beats arm", gate, 0);

        // re-arm after everything
        arm_op(16'd1, 1'b0, "R2 rearm");
        trig_op();
        conv_op(1, 0, "R2 rearm single");

        repeat (6) @(negedge clk);
        check(sb_q.size() == 0, "R3 scoreboard drained", sb_q.size(), 0);
        check(strobes_seen == strobes_exp, "R3 strobe total", strobes_seen, strobes_exp);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule